// File: doc/BRIEF.md
# Front-Panel Power and Reset Button Controller

This block turns the two front-panel pushbuttons into clean control pulses and drives the two panel LEDs. Both buttons arrive raw and active low. Each one is synchronised to the clock. It is then debounced against a millisecond tick, so a press only counts once the input has stayed at one level for a set number of milliseconds.

A power press is timed while the button is held. A short press emits a single-cycle power-management event when the button is released. If the press is still held when the long-press threshold is reached, a single-cycle forced-off request fires at once, and the later release gives no event. A reset press of any length starts a hard-reset pulse of fixed width on its debounced press edge.

The power LED follows the board's powered-on state. The drive-activity LED lights on each activity strobe and stays lit for a minimum visible time after the last strobe, so that brief bursts can be seen. All millisecond timing advances only on the tick input.

Top module: `fpb_panel_ctrl`

## Requirements
- R1: A button level change is accepted only after the synchronised input has differed from the accepted level on DEB_MS consecutive ticks. A raw press of fewer than DEB_MS ticks produces no output at all.
- R2: A power press that is debounced and held for fewer than LONG_MS ticks produces exactly one `pm_event` pulse, one clock wide, after release, and no `force_off`.
- R3: A power press held for LONG_MS ticks produces exactly one `force_off` pulse, one clock wide, while the debounced button is still held. Its release produces no `pm_event`.
- R4: Every debounced reset press, short or long, produces exactly one `hard_reset` pulse of exactly RST_W clock cycles. The pulse starts on the clock after the debounced press edge.
- R5: `pwr_led` equals the value of `pwr_on` one clock earlier.
- R6: `act_led` rises on the clock after a `sata_act` strobe and stays high until ACT_MS ticks have passed since the last strobe. With the tick high on every clock, a single strobe gives ACT_MS cycles, and two strobes N cycles apart give N+ACT_MS cycles.
- R7: With `ms_tick` held low, no button activity changes any output. The debounce and press timers advance only on ticks.
- R8: During and right after reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ms_tick | input | 1 | One-cycle strobe once per millisecond |
| pwr_btn_n | input | 1 | Raw power pushbuttonthat, active low |
| rst_btn_n | input | 1 | Raw reset pushbutton, active low |
| pwr_on | input | 1 | Board is in the powered-on state |
| sata_act | input | 1 | Drive-activity strobe |
| pm_event | output | 1 | Short-press power-management event pulse |
| force_off | output | 1 | Long-press hard power-off request pulse |
| hard_reset | output | 1 | Hard-reset pulse, RST_W cycles |
| pwr_led | output | 1 | Power LED drive, high = lit |
| act_led | output | 1 | Drive-activity LED drive, high = lit |

## Verification
Power presses are walked through a range of hold lengths:
- a glitch below the debounce time, which tells rejection apart from acceptance;
- short holds;
- holds just under and just over the long-press threshold, which separate the soft event from the forced off;
- a long hold, which shows that the forced off comes before release and that no event follows it.

Reset presses of short and very long duration show that the pulse width does not depend on how long the button is held.

Single strobes, spaced strobes and back-to-back strobes show the activity LED retriggering. Holding the tick low shows that no timing advances without it.

// File: rtl/fpb_pkg.sv
package fpb_pkg;
   typedef enum logic [0:0] {
      STR_ONESHOT = 1'b0,
      STR_RETRIG  = 1'b1
   } stretch_mode_e;

   function automatic int cnt_bits(input int max_val);
      return (max_val < 1) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/fpb_debounce.sv
module fpb_debounce #(
   parameter int DEB_MS = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic raw_n,
   output logic level
);
   localparam int CW = fpb_pkg::cnt_bits(DEB_MS);
   localparam logic [CW-1:0] LAST = CW'(DEB_MS - 1);

   logic          sync1, sync2;
   logic [CW-1:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync1   <= 1'b0;
         sync2   <= 1'b0;
         level   <= 1'b0;
         run_cnt <= '0;
      end else begin
         sync1 <= ~raw_n;
         sync2 <= sync1;
         if (sync2 == level) begin
            run_cnt <= '0;
         end else if (tick) begin
            if (run_cnt == LAST) begin
               level   <= sync2;
               run_cnt <= '0;
            end else begin
               run_cnt <= run_cnt + 1'b1;
            end
         end
      end
   end

   // R7: the accepted level can only move on a tick
   a_r7_level_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(level) |-> $past(tick));
   // R1: a new level is taken only from the synchronised input
   a_r1_level_from_sync: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(level) |-> level == $past(sync2));
endmodule

// File: rtl/fpb_press_class.sv
module fpb_press_class #(
   parameter int LONG_MS = 4000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic held,
   output logic short_evt,
   output logic long_off
);
   localparam int CW = fpb_pkg::cnt_bits(LONG_MS);
   localparam logic [CW-1:0] LAST = CW'(LONG_MS - 1);

   logic          held_q;
   logic          long_done;
   logic [CW-1:0] held_ms;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q    <= 1'b0;
         long_done <= 1'b0;
         held_ms   <= '0;
         short_evt <= 1'b0;
         long_off  <= 1'b0;
      end else begin
         held_q    <= held;
         short_evt <= held_q & ~held & ~long_done;
         long_off  <= 1'b0;
         if (!held) begin
            held_ms   <= '0;
            long_done <= 1'b0;
         end else if (tick && !long_done) begin
            if (held_ms == LAST) begin
               long_off  <= 1'b1;
               long_done <= 1'b1;
            end else begin
               held_ms <= held_ms + 1'b1;
            end
         end
      end
   end

   // R2: the soft event is one clock wide
   a_r2_event_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      short_evt |=> !short_evt);
   // R3: the forced off is issued while the press is still held
   a_r3_off_while_held: assert property (@(posedge clk) disable iff (!rst_n)
      long_off |-> held);
   // R3: the forced off is one clock wide
   a_r3_off_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      long_off |=> !long_off);
   // R7: the long-press mark is only reached on a tick
   a_r7_off_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      long_off |-> $past(tick));
endmodule

// File: rtl/fpb_stretch.sv
module fpb_stretch #(
   parameter int                     WIDTH = 16,
   parameter fpb_pkg::stretch_mode_e MODE  = fpb_pkg::STR_ONESHOT
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   input  logic step,
   output logic out
);
   localparam int CW = fpb_pkg::cnt_bits(WIDTH);
   localparam logic [CW-1:0] LOAD = CW'(WIDTH);
   localparam logic [CW-1:0] ONE  = CW'(1);

   logic [CW-1:0] remain;
   logic          load_now;

   generate
      if (MODE == fpb_pkg::STR_RETRIG) begin : g_retrig
         assign load_now = trig;
      end else begin : g_oneshot
         assign load_now = trig && (remain == '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain <= '0;
      end else if (load_now) begin
         remain <= LOAD;
      end else if (step && remain != '0) begin
         remain <= remain - 1'b1;
      end
   end

   assign out = (remain != '0);

   // R4 and R6: once running, the output holds until its last count
   a_r6_stretch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out && remain != ONE) |=> out);
   // R4 and R6: a trigger always lights the output on the next clock
   a_r4_trig_lights: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> out);
endmodule

// File: rtl/fpb_panel_ctrl.sv
module fpb_panel_ctrl #(
   parameter int DEB_MS  = 20,
   parameter int LONG_MS = 4000,
   parameter int RST_W   = 16,
   parameter int ACT_MS  = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ms_tick,
   input  logic pwr_btn_n,
   input  logic rst_btn_n,
   input  logic pwr_on,
   input  logic sata_act,
   output logic pm_event,
   output logic force_off,
   output logic hard_reset,
   output logic pwr_led,
   output logic act_led
);
   if (DEB_MS < 1) begin : g_bad_deb
      $error("DEB_MS must be at least 1");
   end
   if (LONG_MS <= DEB_MS) begin : g_bad_long
      $error("LONG_MS must exceed DEB_MS");
   end
   if (RST_W < 1) begin : g_bad_rst
      $error("RST_W must be at least 1");
   end
   if (ACT_MS < 1) begin : g_bad_act
      $error("ACT_MS must be at least 1");
   end

   logic pwr_held;
   logic rst_held;
   logic rst_held_q;
   logic rst_rise;

   fpb_debounce #(.DEB_MS(DEB_MS)) u_deb_pwr (
      .clk(clk), .rst_n(rst_n), .tick(ms_tick), .raw_n(pwr_btn_n), .level(pwr_held));

   fpb_debounce #(.DEB_MS(DEB_MS)) u_deb_rst (
      .clk(clk), .rst_n(rst_n), .tick(ms_tick), .raw_n(rst_btn_n), .level(rst_held));

   fpb_press_class #(.LONG_MS(LONG_MS)) u_class (
      .clk(clk), .rst_n(rst_n), .tick(ms_tick), .held(pwr_held),
      .short_evt(pm_event), .long_off(force_off));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_held_q <= 1'b0;
         pwr_led    <= 1'b0;
      end else begin
         rst_held_q <= rst_held;
         pwr_led    <= pwr_on;
      end
   end

   assign rst_rise = rst_held & ~rst_held_q;

   fpb_stretch #(.WIDTH(RST_W), .MODE(fpb_pkg::STR_ONESHOT)) u_rst_pulse (
      .clk(clk), .rst_n(rst_n), .trig(rst_rise), .step(1'b1), .out(hard_reset));

   fpb_stretch #(.WIDTH(ACT_MS), .MODE(fpb_pkg::STR_RETRIG)) u_act_led (
      .clk(clk), .rst_n(rst_n), .trig(sata_act), .step(ms_tick), .out(act_led));

   // R5: the power LED tracks the power state one clock later
   a_r5_led_follows: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> pwr_led == $past(pwr_on));
   // R6: a strobe lights the activity LED on the next clock
   a_r6_act_on: assert property (@(posedge clk) disable iff (!rst_n)
      sata_act |=> act_led);
   // R4: a debounced reset press starts the pulse on the next clock
   a_r4_reset_on_press: assert property (@(posedge clk) disable iff (!rst_n)
      rst_rise |=> hard_reset);
   // R2 and R3: a soft event and a forced off never coincide
   a_r3_not_both: assert property (@(posedge clk) disable iff (!rst_n)
      !(pm_event && force_off));
endmodule

// File: tb/tb_fpb_panel_ctrl.sv
module tb_fpb_panel_ctrl;
   localparam int DEB  = 4;
   localparam int LONG = 200;
   localparam int RW   = 8;
   localparam int ACT  = 30;
   localparam int NV   = 7;
   // hold length in cycles (tick every cycle), expected events, expected force-offs
   localparam int VLEN [NV] = '{3, 6, 50, 196, 204, 300, 2};
   localparam int VEV  [NV] = '{0, 1, 1, 1,   0,   0,   0};
   localparam int VOFF [NV] = '{0, 0, 0, 0,   1,   1,   0};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ms_tick = 1'b1;
   logic pwr_btn_n = 1'b1;
   logic rst_btn_n = 1'b1;
   logic pwr_on = 1'b0;
   logic sata_act = 1'b0;
   logic pm_event, force_off, hard_reset, pwr_led, act_led;

   int total = 0;
   int bad = 0;
   int ev_cnt = 0, off_cnt = 0, hr_cnt = 0, hr_len = 0, act_len = 0;
   logic hr_q = 1'b0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   fpb_panel_ctrl #(.DEB_MS(DEB), .LONG_MS(LONG), .RST_W(RW), .ACT_MS(ACT)) dut (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .pwr_btn_n(pwr_btn_n),
      .rst_btn_n(rst_btn_n), .pwr_on(pwr_on), .sata_act(sata_act),
      .pm_event(pm_event), .force_off(force_off), .hard_reset(hard_reset),
      .pwr_led(pwr_led), .act_led(act_led));

   always @(negedge clk) begin
      if (pm_event) ev_cnt++;
      if (force_off) off_cnt++;
      if (hard_reset) hr_len++;
      if (hard_reset && !hr_q) hr_cnt++;
      hr_q <= hard_reset;
      if (act_led) act_len++;
   end

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_counts();
      ev_cnt = 0; off_cnt = 0; hr_cnt = 0; hr_len = 0; act_len = 0;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      wait_cyc(3);
      // R8: outputs low while in reset
      check("R8 reset outputs", {pm_event, force_off, hard_reset, pwr_led, act_led}, 0);
      rst_n = 1'b1;
      wait_cyc(3);
      check("R8 after reset outputs", {pm_event, force_off, hard_reset, pwr_led, act_led}, 0);

      // R1 R2 R3: vector table of power press lengths
      for (int i = 0; i < NV; i++) begin
         clear_counts();
         pwr_btn_n = 1'b0;
         wait_cyc(VLEN[i]);
         pwr_btn_n = 1'b1;
         if (VLEN[i] == 300)
            check("R3 force_off before release", off_cnt, 1);
         wait_cyc(40);
         check($sformatf("R2 events len=%0d", VLEN[i]), ev_cnt, VEV[i]);
         check($sformatf("R3 force_off len=%0d", VLEN[i]), off_cnt, VOFF[i]);
         check($sformatf("R1 no reset side effect len=%0d", VLEN[i]), hr_cnt, 0);
      end

      // R4: short and very long reset presses give one pulse of RW cycles
      foreach (VLEN[j]) begin
         if (VLEN[j] == 6 || VLEN[j] == 300) begin
            clear_counts();
            rst_btn_n = 1'b0;
            wait_cyc(VLEN[j]);
            rst_btn_n = 1'b1;
            wait_cyc(40);
            check($sformatf("R4 pulse count len=%0d", VLEN[j]), hr_cnt, 1);
            check($sformatf("R4 pulse width len=%0d", VLEN[j]), hr_len, RW);
            check("R4 no power outputs", ev_cnt + off_cnt, 0);
         end
      end

      // R1: reset glitch below debounce is rejected
      clear_counts();
      rst_btn_n = 1'b0;
      wait_cyc(DEB - 1);
      rst_btn_n = 1'b1;
      wait_cyc(30);
      check("R1 reset glitch", hr_cnt, 0);

      // R5: power LED follows power state one clock later
      pwr_on = 1'b1;
      wait_cyc(1);
      check("R5 led on", pwr_led, 1);
      pwr_on = 1'b0;
      wait_cyc(1);
      check("R5 led off", pwr_led, 0);

      // R6: single strobe
      clear_counts();
      sata_act = 1'b1;
      wait_cyc(1);
      sata_act = 1'b0;
      wait_cyc(ACT + 10);
      check("R6 single strobe width", act_len, ACT);
      // R6: two strobes 10 apart retrigger
      clear_counts();
      sata_act = 1'b1;
      wait_cyc(1);
      sata_act = 1'b0;
      wait_cyc(9);
      sata_act = 1'b1;
      wait_cyc(1);
      sata_act = 1'b0;
      wait_cyc(ACT + 20);
      check("R6 two strobe width", act_len, 10 + ACT);
      // R6: burst of five back-to-back strobes
      clear_counts();
      sata_act = 1'b1;
      wait_cyc(5);
      sata_act = 1'b0;
      wait_cyc(ACT + 20);
      check("R6 burst width", act_len, 4 + ACT);

      // R7: no tick, no timing; a long press and a reset press do nothing
      clear_counts();
      ms_tick = 1'b0;
      pwr_btn_n = 1'b0;
      rst_btn_n = 1'b0;
      wait_cyc(300);
      pwr_btn_n = 1'b1;
      rst_btn_n = 1'b1;
      wait_cyc(20);
      ms_tick = 1'b1;
      wait_cyc(40);
      check("R7 no event without tick", ev_cnt + off_cnt, 0);
      check("R7 no reset without tick", hr_cnt, 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule